// File: doc/BRIEF.md
# DDR 1:10 Serializer with Forwarded Clock

This block turns a parallel word into a serial stream for one output lane. Once per cycle of a slow regional clock it samples a 16-bit word, of which only the low ten bits carry data, and sends those ten bits out on both edges of a fast I/O clock. The fast clock runs at exactly five times the slow rate, and the two clocks are edge-aligned. Each fast cycle carries two bits: the first in the high half and the second in the low half.

Alongside the data the block drives a forwarded copy of the fast clock. The forwarded clock can be switched off or inverted while the block runs. A per-lane direction bit decides whether the lane drives its data or is released so that the pad can be used for acquisition.

Every control input goes through the same two-stage slow pipeline as the data. Direction, clock enable and clock polarity therefore change at the same frame boundary as the word they were sampled with. That boundary is where the fast-side register loads, so switching the forwarded clock never produces a runt pulse.

The slow side holds two state machines:
- Lane machine, states `LANE_RELEASED` and `LANE_DRIVE`. Transition GO_DRIVE fires when the registered direction is 1. Transition GO_RELEASE fires when it is 0.
- Forwarded-clock machine, states `FWD_OFF`, `FWD_TRUE` and `FWD_INVERTED`.
  - From any state, a registered enable of 0 moves it to `FWD_OFF` (STOP).
  - An enable of 1 moves it to `FWD_TRUE` when the invert control is 0 (RUN).
  - An enable of 1 moves it to `FWD_INVERTED` when the invert control is 1 (RUN_INV).

Top module: `ddr_serializer_tx`

## Requirements
- R1: Data goes out MSB-first: word bit 9 is sent in the high half of the first fast cycle of a frame, bit 8 in its low half, and so on down to bit 0 in the low half of the fifth fast cycle.
- R2: Word bits 15 down to 10 have no effect on the serial output.
- R3: Frames follow each other back to back. Each slow cycle carries one full ten-bit frame made of five fast cycles, with no gap and no repeated bit.
- R4: A word sampled at slow rising edge N is on the serial output from slow edge N+2 until edge N+3.
- R5: When the clock-out enable sampled for a frame is 0, the forwarded clock stays at 0 for that whole frame.
- R6: When enabled, the forwarded clock follows the fast clock if the invert control is 0. It is the complement of the fast clock if the invert control is 1.
- R7: A direction bit of 1 drives the lane: output enable is 1 and the data appears. A direction bit of 0 releases it: output enable is 0 and the serial output is 0. Direction follows the same two-cycle latency as the data.
- R8: While reset is high, the serial output, output enable and forwarded clock are all 0.
- R9: A change of clock-out enable or invert sampled at slow edge N takes effect exactly at slow edge N+2, the same frame boundary as the word sampled with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow regional clock; one frame per cycle |
| clk_fast | input | 1 | Fast I/O clock, five times clk_slow, edge-aligned |
| rst | input | 1 | Synchronous active-high reset for both domains |
| dir_i | input | 1 | Lane direction: 1 drives, 0 releases |
| word_i | input | 16 | Parallel word; bits 9..0 are sent, 15..10 ignored |
| ck_en_i | input | 1 | Forwarded clock enable |
| ck_inv_i | input | 1 | Forwarded clock polarity invert |
| ser_o | output | 1 | Serial DDR data |
| oe_o | output | 1 | Output-enable flag for the lane |
| ck_o | output | 1 | Forwarded clock |

## Verification
Inputs are driven one time unit after a slow rising edge N. They are first sampled at edge N+1, so the whole frame built from them appears from edge N+3 onward. The bench accordingly compares each slot against the stimulus driven three slots earlier. In the two slots after reset it expects all-zero outputs. Within a slot it samples ten times, two units after each fast edge, so each sample lands in the middle of a DDR half-period. Bit index j of a slot is checked against word bit 9-j, and against the forwarded clock level implied by j being even (fast clock high).

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;

    typedef enum logic [0:0] {
        LANE_RELEASED = 1'b0,
        LANE_DRIVE    = 1'b1
    } lane_state_e;

    typedef enum logic [1:0] {
        FWD_OFF      = 2'd0,
        FWD_TRUE     = 2'd1,
        FWD_INVERTED = 2'd2
    } fwd_state_e;

endpackage

// File: rtl/ddr_ser_ctrl.sv
// Slow-domain front end: input capture, lane and forwarded-clock state
// machines, and the frame toggle the fast side aligns to.
module ddr_ser_ctrl
    import ddr_ser_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int FRAME_W = 10
) (
    input  logic               clk_slow,
    input  logic               rst,
    input  logic               dir_i,
    input  logic [WORD_W-1:0]  word_i,
    input  logic               ck_en_i,
    input  logic               ck_inv_i,
    output logic [FRAME_W-1:0] tx_word_o,
    output logic               tx_oe_o,
    output logic               fwd_en_o,
    output logic               fwd_inv_o,
    output logic               tgl_o
);

    // stage 1: sampled inputs
    logic [FRAME_W-1:0] word_q;
    logic               dir_q;
    logic               en_q;
    logic               inv_q;
    // stage 2: state and frame word
    lane_state_e        lane_q, lane_nx;
    fwd_state_e         fwd_q, fwd_nx;
    logic [FRAME_W-1:0] tx_q;
    logic               tgl_q;

    // R2: the upper word bits are dropped here
    logic unused_hi;
    assign unused_hi = ^word_i[WORD_W-1:FRAME_W];

    always_ff @(posedge clk_slow) begin
        if (rst) begin
            word_q <= '0;
            dir_q  <= 1'b0;
            en_q   <= 1'b0;
            inv_q  <= 1'b0;
            lane_q <= LANE_RELEASED;
            fwd_q  <= FWD_OFF;
            tx_q   <= '0;
            tgl_q  <= 1'b0;
        end else begin
            word_q <= word_i[FRAME_W-1:0];
            dir_q  <= dir_i;
            en_q   <= ck_en_i;
            inv_q  <= ck_inv_i;
            lane_q <= lane_nx;
            fwd_q  <= fwd_nx;
            tx_q   <= (lane_nx == LANE_DRIVE) ? word_q : '0;
            tgl_q  <= ~tgl_q;
        end
    end

    // next-state logic
    always_comb begin
        lane_nx = lane_q;
        unique case (lane_q)
            LANE_RELEASED: if (dir_q)  lane_nx = LANE_DRIVE;    // GO_DRIVE
            LANE_DRIVE:    if (!dir_q) lane_nx = LANE_RELEASED; // GO_RELEASE
            default:       lane_nx = LANE_RELEASED;
        endcase

        fwd_nx = fwd_q;
        unique case (fwd_q)
            FWD_OFF: begin
                if (en_q) fwd_nx = inv_q ? FWD_INVERTED : FWD_TRUE;  // RUN / RUN_INV
            end
            FWD_TRUE: begin
                if (!en_q)     fwd_nx = FWD_OFF;                     // STOP
                else if (inv_q) fwd_nx = FWD_INVERTED;               // RUN_INV
            end
            FWD_INVERTED: begin
                if (!en_q)      fwd_nx = FWD_OFF;                    // STOP
                else if (!inv_q) fwd_nx = FWD_TRUE;                  // RUN
            end
            default: fwd_nx = FWD_OFF;
        endcase
    end

    // outputs from state
    always_comb begin
        tx_word_o = tx_q;
        tgl_o     = tgl_q;
        unique case (lane_q)
            LANE_DRIVE: tx_oe_o = 1'b1;
            default:    tx_oe_o = 1'b0;
        endcase
        unique case (fwd_q)
            FWD_TRUE: begin
                fwd_en_o  = 1'b1;
                fwd_inv_o = 1'b0;
            end
            FWD_INVERTED: begin
                fwd_en_o  = 1'b1;
                fwd_inv_o = 1'b1;
            end
            default: begin
                fwd_en_o  = 1'b0;
                fwd_inv_o = 1'b0;
            end
        endcase
    end

    // R4 / R2: frame word is the low bits sampled two slow edges earlier
    p_latency_r4: assert property (@(posedge clk_slow) disable iff (rst)
        (lane_q == LANE_DRIVE) |-> (tx_q == $past(word_i[FRAME_W-1:0], 2)));

    // R7: a sampled drive request reaches the lane state one edge later
    p_dir_follow_r7: assert property (@(posedge clk_slow) disable iff (rst)
        dir_q |=> (lane_q == LANE_DRIVE));

    // R9: enabled and inverted request selects the inverted clock state
    p_fwd_follow_r9: assert property (@(posedge clk_slow) disable iff (rst)
        (en_q && inv_q) |=> (fwd_q == FWD_INVERTED));

endmodule

// File: rtl/ddr_ser_gearbox.sv
// Fast-domain gearbox: aligns to the slow frame toggle, loads one frame
// per slow cycle, and shifts out two bits per fast cycle.
module ddr_ser_gearbox #(
    parameter int FRAME_W = 10,
    parameter int RATIO   = 5
) (
    input  logic               clk_fast,
    input  logic               rst,
    input  logic               tgl_i,
    input  logic [FRAME_W-1:0] tx_word_i,
    input  logic               tx_oe_i,
    output logic               load_o,
    output logic               ser_o,
    output logic               oe_o
);

    localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam int SH_W = FRAME_W - 2;

    logic            seen_q;
    logic [PH_W-1:0] phase_q;
    logic [1:0]      pair_q;   // [1] high half, [0] low half
    logic [SH_W-1:0] sh_q;
    logic            oe_q;
    logic            load;

    assign load = (int'(phase_q) == RATIO - 1);

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            seen_q  <= 1'b0;
            phase_q <= '0;
            pair_q  <= 2'b00;
            sh_q    <= '0;
            oe_q    <= 1'b0;
        end else begin
            seen_q <= tgl_i;
            if (tgl_i != seen_q)
                phase_q <= PH_W'(1);
            else if (load)
                phase_q <= '0;
            else
                phase_q <= phase_q + PH_W'(1);

            if (load) begin
                pair_q <= tx_word_i[FRAME_W-1 -: 2];
                sh_q   <= tx_word_i[SH_W-1:0];
                oe_q   <= tx_oe_i;
            end else begin
                pair_q <= sh_q[SH_W-1 -: 2];
                sh_q   <= {sh_q[SH_W-3:0], 2'b00};
            end
        end
    end

    // DDR output cell: high half carries pair bit 1, low half pair bit 0
    assign ser_o  = oe_q & (clk_fast ? pair_q[1] : pair_q[0]);
    assign oe_o   = oe_q;
    assign load_o = load;

    // R3: phase counter never leaves the frame range
    p_phase_range_r3: assert property (@(posedge clk_fast) disable iff (rst)
        (int'(phase_q) < RATIO));

    // R4: a frame load only lands on a slow boundary, never mid-frame
    p_load_aligned_r4: assert property (@(posedge clk_fast) disable iff (rst)
        load |-> (tgl_i == seen_q));

    // R7: a released lane never holds data bits in flight
    p_released_quiet_r7: assert property (@(posedge clk_fast) disable iff (rst)
        !oe_q |-> ((pair_q == 2'b00) && (sh_q == '0)));

endmodule

// File: rtl/ddr_ser_clkfwd.sv
// Forwarded clock: enable and polarity latched only at frame loads.
module ddr_ser_clkfwd (
    input  logic clk_fast,
    input  logic rst,
    input  logic load_i,
    input  logic en_i,
    input  logic inv_i,
    output logic ck_o
);

    logic en_q;
    logic inv_q;

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            en_q  <= 1'b0;
            inv_q <= 1'b0;
        end else if (load_i) begin
            en_q  <= en_i;
            inv_q <= inv_i;
        end
    end

    assign ck_o = en_q & (clk_fast ^ inv_q);

    // R9: controls of the forwarded clock move only at a frame load
    p_fwd_hold_r9: assert property (@(posedge clk_fast) disable iff (rst)
        !load_i |=> ($stable(en_q) && $stable(inv_q)));

endmodule

// File: rtl/ddr_serializer_tx.sv
module ddr_serializer_tx #(
    parameter int WORD_W  = 16,
    parameter int FRAME_W = 10
) (
    input  logic              clk_slow,
    input  logic              clk_fast,
    input  logic              rst,
    input  logic              dir_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              ck_en_i,
    input  logic              ck_inv_i,
    output logic              ser_o,
    output logic              oe_o,
    output logic              ck_o
);

    localparam int RATIO = FRAME_W / 2;

    logic [FRAME_W-1:0] tx_word;
    logic               tx_oe;
    logic               fwd_en;
    logic               fwd_inv;
    logic               tgl;
    logic               load;

    ddr_ser_ctrl #(
        .WORD_W  (WORD_W),
        .FRAME_W (FRAME_W)
    ) ctrl_i (
        .clk_slow  (clk_slow),
        .rst       (rst),
        .dir_i     (dir_i),
        .word_i    (word_i),
        .ck_en_i   (ck_en_i),
        .ck_inv_i  (ck_inv_i),
        .tx_word_o (tx_word),
        .tx_oe_o   (tx_oe),
        .fwd_en_o  (fwd_en),
        .fwd_inv_o (fwd_inv),
        .tgl_o     (tgl)
    );

    ddr_ser_gearbox #(
        .FRAME_W (FRAME_W),
        .RATIO   (RATIO)
    ) gbox_i (
        .clk_fast  (clk_fast),
        .rst       (rst),
        .tgl_i     (tgl),
        .tx_word_i (tx_word),
        .tx_oe_i   (tx_oe),
        .load_o    (load),
        .ser_o     (ser_o),
        .oe_o      (oe_o)
    );

    ddr_ser_clkfwd fwd_i (
        .clk_fast (clk_fast),
        .rst      (rst),
        .load_i   (load),
        .en_i     (fwd_en),
        .inv_i    (fwd_inv),
        .ck_o     (ck_o)
    );

endmodule

// File: tb/ddr_serializer_tx_tb_top.sv
module ddr_serializer_tx_tb_top;

    localparam int NS = 240;   // stimulus slots
    localparam int FW = 10;

    logic        clk_fast, clk_slow, rst;
    logic        dir_i, ck_en_i, ck_inv_i;
    logic [15:0] word_i;
    logic        ser_o, oe_o, ck_o;

    logic [15:0] s_word [NS];
    bit          s_dir  [NS];
    bit          s_en   [NS];
    bit          s_inv  [NS];
    int          s_req  [NS];
    int          n_st;
    int          n_chk, n_fail;
    bit          done;

    ddr_serializer_tx dut_i (
        .clk_slow (clk_slow),
        .clk_fast (clk_fast),
        .rst      (rst),
        .dir_i    (dir_i),
        .word_i   (word_i),
        .ck_en_i  (ck_en_i),
        .ck_inv_i (ck_inv_i),
        .ser_o    (ser_o),
        .oe_o     (oe_o),
        .ck_o     (ck_o)
    );

    // fast clock period 10 units (100 MHz); slow clock rises on every fifth fast edge
    int ph;
    initial begin
        clk_fast = 1'b0;
        clk_slow = 1'b0;
        ph = 0;
        forever begin
            #5; clk_fast = 1'b1; if (ph == 0) clk_slow = 1'b1;
            #5; clk_fast = 1'b0; if (ph == 2) clk_slow = 1'b0;
            ph = (ph == 4) ? 0 : ph + 1;
        end
    end

    task automatic check(int req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic put(logic [15:0] w, bit d, bit e, bit i, int r);
        s_word[n_st] = w; s_dir[n_st] = d; s_en[n_st] = e; s_inv[n_st] = i; s_req[n_st] = r;
        n_st++;
    endtask

    // expected serial bit j of frame built from slot k (MSB-first, zero when released)
    function automatic logic exp_ser(int k, int j);
        return s_dir[k] ? s_word[k][FW-1-j] : 1'b0;
    endfunction

    // expected forwarded clock: fast clock high on even j
    function automatic logic exp_ck(int k, int j);
        logic hi;
        hi = ((j % 2) == 0);
        return s_en[k] ? (hi ^ s_inv[k]) : 1'b0;
    endfunction

    task automatic drive(int k);
        word_i = s_word[k]; dir_i = s_dir[k]; ck_en_i = s_en[k]; ck_inv_i = s_inv[k];
    endtask

    initial begin
        n_chk = 0; n_fail = 0; done = 0; n_st = 0;
        void'($urandom(32'h1F2E3D4C));
        // R1: single bits at both ends and alternating patterns
        put(16'h0200, 1, 1, 0, 1); put(16'h0001, 1, 1, 0, 1);
        put(16'h02AA, 1, 1, 0, 1); put(16'h0155, 1, 1, 0, 1);
        // R2: upper bits set must not leak into the frame
        put(16'hFC00, 1, 1, 0, 2); put(16'hFD5A, 1, 1, 0, 2);
        // R4: isolated word between zeros
        put(16'h0000, 1, 1, 0, 4); put(16'h03FF, 1, 1, 0, 4);
        put(16'h0000, 1, 1, 0, 4); put(16'h0000, 1, 1, 0, 4);
        // R5: forwarded clock disabled
        put(16'h0123, 1, 0, 0, 5); put(16'h0321, 1, 0, 1, 5);
        // R6: inverted forwarded clock
        put(16'h00F0, 1, 1, 1, 6); put(16'h030F, 1, 1, 1, 6);
        // R7: released lane with data present, then drive, then release
        put(16'h03FF, 0, 1, 0, 7); put(16'h03FF, 0, 1, 0, 7);
        put(16'h03FF, 1, 1, 0, 7); put(16'h03FF, 0, 1, 0, 7);
        // R9: enable and polarity toggled every frame
        put(16'h0155, 1, 0, 0, 9); put(16'h0155, 1, 1, 1, 9);
        put(16'h0155, 1, 0, 1, 9); put(16'h0155, 1, 1, 0, 9);
        // R3: back-to-back extreme frames
        put(16'h03FF, 1, 1, 0, 3); put(16'h0000, 1, 1, 0, 3);
        put(16'h03FF, 1, 1, 0, 3); put(16'h0000, 1, 1, 0, 3);
        // R3: constrained random remainder (lane mostly driving)
        while (n_st < NS)
            put(16'($urandom), (($urandom % 4) != 0), 1'($urandom), 1'($urandom), 3);

        rst = 1'b1;
        word_i = 16'h03FF; dir_i = 1'b1; ck_en_i = 1'b1; ck_inv_i = 1'b0;
        repeat (3) @(posedge clk_slow);
        // R8: outputs quiet under reset even with active inputs
        @(posedge clk_slow); #2;
        for (int j = 0; j < FW; j++) begin
            check(8, "ser in reset", ser_o, 1'b0);
            check(8, "oe in reset", oe_o, 1'b0);
            check(8, "ck in reset", ck_o, 1'b0);
            if (j < FW - 1) #5;
        end
        @(posedge clk_slow); #1;
        rst = 1'b0;
        drive(0);

        for (int n = 0; n < NS + 2; n++) begin
            @(posedge clk_slow); #1;
            if (n + 1 < NS) drive(n + 1);
            #1;
            for (int j = 0; j < FW; j++) begin
                if (n >= 2) begin
                    check(s_req[n-2], "ser", ser_o, exp_ser(n - 2, j));
                    check(s_req[n-2] == 7 ? 7 : 4, "oe", oe_o, s_dir[n-2]);
                    check(s_req[n-2] == 5 || s_req[n-2] == 6 ? s_req[n-2] : 9, "ck", ck_o, exp_ck(n - 2, j));
                end else begin
                    // R4: pipeline not yet filled, outputs still idle
                    check(4, "ser fill", ser_o, 1'b0);
                    check(4, "oe fill", oe_o, 1'b0);
                    check(5, "ck fill", ck_o, 1'b0);
                end
                if (j < FW - 1) #5;
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule